// File: doc/BRIEF.md
# SDR SDRAM Access Controller

This controller sits between a simple single-word host port and one rank of single-data-rate SDRAM with four banks, 12-bit rows and 9-bit columns. It accepts one read or write request at a time through a valid/ready handshake. It turns each request into an activate, followed by a read or write that carries auto precharge, so no row is left open after an access. Read data comes back on a one-cycle valid pulse after the programmed CAS latency.

After reset the controller drives NOP for a parameterised settling time. It then precharges all banks, issues two auto refreshes and programs the mode register for single-word bursts, sequential order and the configured CAS latency. From then on an interval timer raises a refresh request. That request is served as soon as the current access has recovered, ahead of any waiting host request. Every timing gap comes from nanosecond parameters rounded up to whole clocks at elaboration.

Top module: `sdram_ctrl`

## Requirements
- R1: While rst_ni is low: cke_o is 0, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), dqm_o is all ones, and req_ready_o and rd_valid_o are 0.
- R2: After reset, the command pins show only NOP for at least PWRUP_CYCLES clocks. Then come precharge-all (addr_o[10] = 1), two auto refreshes and a mode register set with addr_o = CAS_LAT<<4 (bits 2:0 = 000 for burst length 1, bit 3 = 0 for sequential order) and ba_o = 0. req_ready_o stays 0 until that sequence is done.
- R3: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as: mode set 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111. No other code is ever driven.
- R4: A request address is {bank[22:21], row[20:9], col[8:0]}. The activate drives ba_o = bank and addr_o = row. The following read or write drives the same ba_o, addr_o[8:0] = col, addr_o[10] = 1 (auto precharge) and all other address bits 0.
- R5: The read or write follows its activate exactly ceil(tRCD/tCK) cycles later.
- R6: Consecutive activate/refresh commands are at least max(tRC, tRAS+tRP, tRRD) cycles apart, rounded up. Any activate, refresh or mode set comes at least tRDL+ceil(tRP/tCK) cycles after a write.
- R7: The data bus is driven with the request data only in the write command cycle, and dqm_o then equals the inverse of the byte enables. On a read command dqm_o is 0.
- R8: Read data present on the bus CAS_LAT cycles after the memory samples the read is returned on rd_data_o with rd_valid_o high for exactly one cycle. That cycle directly follows the capturing edge.
- R9: After initialisation a refresh is issued every REF_INTERVAL cycles within a small serving delay, and only when no bank is open.
- R10: When a refresh falls due while a host request is waiting, the refresh is issued first and the request follows it after the row-cycle gap.
- R11: Each request is accepted exactly once on a cycle with req_valid_i and req_ready_o both high, and accesses are carried out in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller can take a request this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 23 | Word address {bank,row,col} |
| req_wdata_i | input | 64 | Write data |
| req_be_i | input | 8 | Write byte enables |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 64 | Read data |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 12 | Multiplexed row/column/mode address |
| dqm_o | output | 8 | Byte data mask |
| dq_io | inout | 64 | Bidirectional data bus |

## Verification
The refresh timer and the host port can both want the command bus in the same cycle. The bench provokes this by holding req_valid_i high through a long run of back-to-back accesses, so that several refresh deadlines expire while a request is waiting. A memory model on the pins then checks three things at each refresh: no bank is open, the refresh keeps the row-cycle and write-recovery gaps, and it is counted as served under pressure. The scoreboard still requires every waiting request to complete in order with correct data.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } cmd_e;

  function automatic int ps2cyc(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(INTERVAL - 1);
      pend_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= CW'(INTERVAL - 1);
      pend_q <= 1'b0;
    end else begin
      if (ack_i) pend_q <= 1'b0;
      if (cnt_q == '0) begin
        cnt_q  <= CW'(INTERVAL - 1);
        pend_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W  = 64,
  parameter int CAS_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_cmd_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  // bit k set: read was sampled by the memory k+1 edges ago
  logic [CAS_LAT-1:0] sh_q;
  logic               valid_q;
  logic [DATA_W-1:0]  data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      sh_q    <= {sh_q[CAS_LAT-2:0], rd_cmd_i};
      valid_q <= sh_q[CAS_LAT-1];
      if (sh_q[CAS_LAT-1]) data_q <= dq_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int CLK_PS       = 10000,
  parameter int T_RCD_PS     = 20000,
  parameter int T_RP_PS      = 20000,
  parameter int T_RAS_PS     = 50000,
  parameter int T_RC_PS      = 70000,
  parameter int T_RRD_PS     = 20000,
  parameter int T_RDL_CYC    = 2,
  parameter int T_MRD_CYC    = 2,
  parameter int CAS_LAT      = 2,
  parameter int REF_INTERVAL = 780,
  parameter int PWRUP_CYCLES = 20000,
  parameter int INIT_REFS    = 2,
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic                          req_we_i,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]             req_wdata_i,
  input  logic [DATA_W/8-1:0]           req_be_i,
  output logic                          rd_valid_o,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          cke_o,
  output logic                          cs_n_o,
  output logic                          ras_n_o,
  output logic                          cas_n_o,
  output logic                          we_n_o,
  output logic [BANK_W-1:0]             ba_o,
  output logic [ROW_W-1:0]              addr_o,
  output logic [DATA_W/8-1:0]           dqm_o,
  inout  wire  [DATA_W-1:0]             dq_io
);
  localparam int BE_W      = DATA_W / 8;
  localparam int ROW_LSB   = COL_W;
  localparam int BANK_LSB  = COL_W + ROW_W;
  localparam int T_RCD     = ps2cyc(T_RCD_PS, CLK_PS);
  localparam int T_RP      = ps2cyc(T_RP_PS, CLK_PS);
  localparam int T_RAS     = ps2cyc(T_RAS_PS, CLK_PS);
  localparam int T_RC      = ps2cyc(T_RC_PS, CLK_PS);
  localparam int T_RRD     = ps2cyc(T_RRD_PS, CLK_PS);
  localparam int ACT_CYCLE = max2(max2(T_RC, T_RAS + T_RP), T_RRD);
  localparam int WR_GAP    = max2(T_RDL_CYC + T_RP, ACT_CYCLE - T_RCD);
  localparam int RD_GAP    = max2(1 + T_RP, ACT_CYCLE - T_RCD);
  localparam int CNT_MAX   = max2(PWRUP_CYCLES, max2(ACT_CYCLE, max2(WR_GAP, RD_GAP)));
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int IREF_W    = $clog2(INIT_REFS + 1);
  localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1) << 10;
  localparam logic [ROW_W-1:0] MRS_OP  = ROW_W'(CAS_LAT << 4);

  typedef enum logic [2:0] {ST_PWRUP, ST_IREF, ST_MRS, ST_IDLE, ST_COL} st_e;

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IREF_W-1:0] iref_q;
  logic              init_done_q;
  cmd_e              cmd_q;
  logic              cke_q;
  logic [BANK_W-1:0] ba_q;
  logic [ROW_W-1:0]  addr_q;
  logic [BE_W-1:0]   dqm_q;
  logic              dq_oe_q;
  logic              we_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wd_q;
  logic [BE_W-1:0]   be_q;
  logic              ref_pend;
  logic              ref_ack;
  logic              slot_free;

  assign slot_free   = (st_q == ST_IDLE) && (cnt_q == '0);
  assign ref_ack     = slot_free && ref_pend;
  assign req_ready_o = slot_free && !ref_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_PWRUP;
      cnt_q       <= CNT_W'(PWRUP_CYCLES - 1);
      iref_q      <= '0;
      init_done_q <= 1'b0;
      cmd_q       <= CMD_NOP;
      cke_q       <= 1'b0;
      ba_q        <= '0;
      addr_q      <= '0;
      dqm_q       <= '1;
      dq_oe_q     <= 1'b0;
      we_q        <= 1'b0;
      col_q       <= '0;
      wd_q        <= '0;
      be_q        <= '0;
    end else begin
      cke_q   <= 1'b1;
      cmd_q   <= CMD_NOP;
      dq_oe_q <= 1'b0;
      dqm_q   <= '0;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end else begin
        unique case (st_q)
          ST_PWRUP: begin
            cmd_q  <= CMD_PRE;
            addr_q <= AP_MASK;
            iref_q <= IREF_W'(INIT_REFS);
            cnt_q  <= CNT_W'(T_RP - 1);
            st_q   <= ST_IREF;
          end
          ST_IREF: begin
            cmd_q  <= CMD_REF;
            iref_q <= iref_q - IREF_W'(1);
            cnt_q  <= CNT_W'(ACT_CYCLE - 1);
            if (iref_q == IREF_W'(1)) st_q <= ST_MRS;
          end
          ST_MRS: begin
            cmd_q       <= CMD_MRS;
            ba_q        <= '0;
            addr_q      <= MRS_OP;
            cnt_q       <= CNT_W'(T_MRD_CYC - 1);
            init_done_q <= 1'b1;
            st_q        <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_pend) begin
              cmd_q <= CMD_REF;
              cnt_q <= CNT_W'(ACT_CYCLE - 1);
            end else if (req_valid_i) begin
              cmd_q  <= CMD_ACT;
              ba_q   <= req_addr_i[BANK_LSB +: BANK_W];
              addr_q <= req_addr_i[ROW_LSB +: ROW_W];
              col_q  <= req_addr_i[COL_W-1:0];
              we_q   <= req_we_i;
              wd_q   <= req_wdata_i;
              be_q   <= req_be_i;
              cnt_q  <= CNT_W'(T_RCD - 1);
              st_q   <= ST_COL;
            end
          end
          ST_COL: begin
            cmd_q   <= we_q ? CMD_WR : CMD_RD;
            addr_q  <= ROW_W'(col_q) | AP_MASK;
            dq_oe_q <= we_q;
            dqm_q   <= we_q ? ~be_q : '0;
            cnt_q   <= we_q ? CNT_W'(WR_GAP - 1) : CNT_W'(RD_GAP - 1);
            st_q    <= ST_IDLE;
          end
          default: st_q <= ST_PWRUP;
        endcase
      end
    end
  end

  sdram_refresh_timer #(
    .INTERVAL(REF_INTERVAL)
  ) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (init_done_q),
    .ack_i (ref_ack),
    .pend_o(ref_pend)
  );

  sdram_rd_capture #(
    .DATA_W (DATA_W),
    .CAS_LAT(CAS_LAT)
  ) u_rdcap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_cmd_i(cmd_q == CMD_RD),
    .dq_i    (dq_io),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign cke_o  = cke_q;
  assign ba_o   = ba_q;
  assign addr_o = addr_q;
  assign dqm_o  = dqm_q;
  assign dq_io  = dq_oe_q ? wd_q : 'z;
endmodule

// File: rtl/sdram_ctrl_checker.sv
module sdram_ctrl_checker
  import sdram_ctrl_pkg::*;
#(
  parameter int RCD     = 2,
  parameter int ACT_CYC = 7,
  parameter int WR_REC  = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] cmd_i,
  input logic       a10_i,
  input logic       dq_oe_i,
  input logic       rd_valid_i
);
  logic [7:0] since_act, since_row, since_wr;

  function automatic logic [7:0] sat_inc(input logic [7:0] v);
    return (v == 8'hff) ? v : v + 8'd1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= 8'hff;
      since_row <= 8'hff;
      since_wr  <= 8'hff;
    end else begin
      since_act <= (cmd_i == CMD_ACT) ? 8'd1 : sat_inc(since_act);
      since_row <= (cmd_i == CMD_ACT || cmd_i == CMD_REF) ? 8'd1 : sat_inc(since_row);
      since_wr  <= (cmd_i == CMD_WR) ? 8'd1 : sat_inc(since_wr);
    end
  end

  a_r5_rcd_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RD || cmd_i == CMD_WR) |-> since_act == 8'(RCD));

  a_r6_row_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ACT || cmd_i == CMD_REF) |-> since_row >= 8'(ACT_CYC));

  a_r6_write_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ACT || cmd_i == CMD_REF || cmd_i == CMD_MRS) |-> since_wr >= 8'(WR_REC));

  a_r4_auto_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RD || cmd_i == CMD_WR) |-> a10_i);

  a_r7_drive_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_i == (cmd_i == CMD_WR));

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> !rd_valid_i);

  a_r3_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i inside {CMD_MRS, CMD_REF, CMD_PRE, CMD_ACT, CMD_WR, CMD_RD, CMD_NOP});
endmodule

bind sdram_ctrl sdram_ctrl_checker #(
  .RCD    (T_RCD),
  .ACT_CYC(ACT_CYCLE),
  .WR_REC (T_RDL_CYC + T_RP)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_i     ({cs_n_o, ras_n_o, cas_n_o, we_n_o}),
  .a10_i     (addr_o[10]),
  .dq_oe_i   (dq_oe_q),
  .rd_valid_i(rd_valid_o)
);

// File: tb/tb_sdram_ctrl.sv
module tb_sdram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CL       = 3;
  localparam int PWR      = 100;
  localparam int RI       = 300;
  localparam int T_RCD    = 2;
  localparam int ACT_CYC  = 7;
  localparam int WR_REC   = 4;

  typedef struct packed {
    logic        we;
    logic [1:0]  ba;
    logic [11:0] row;
    logic [8:0]  col;
    logic [63:0] wd;
    logic [7:0]  be;
  } acc_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [22:0] req_addr;
  logic [63:0] req_wdata;
  logic [7:0]  req_be;
  logic        req_ready, rd_valid, cke, cs_n, ras_n, cas_n, we_n;
  logic [63:0] rd_data;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [7:0]  dqm;
  wire  [63:0] dq;

  logic        pv [CL];
  logic [63:0] pd [CL];
  assign dq = pv[CL-1] ? pd[CL-1] : 'z;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_ctrl #(
    .CAS_LAT(CL), .REF_INTERVAL(RI), .PWRUP_CYCLES(PWR)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .dqm_o(dqm), .dq_io(dq)
  );

  int checks = 0, errors = 0;
  int cyc = 0, rst_cyc = 0;
  acc_t        exp_q[$];
  logic [63:0] exp_rd[$];
  int          rd_cyc_q[$];
  logic [63:0] shadow [logic [22:0]];
  logic [63:0] mem    [logic [22:0]];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model and pin-level protocol monitor
  int   last_act = -1000, last_row = -1000, last_wr = -1000, last_ref = -1, mrs_cyc = -1;
  int   init_refs = 0, refs_post = 0, refs_busy = 0;
  bit   pre_seen = 0, mrs_seen = 0;
  bit   bank_open [4];
  logic [11:0] open_row [4];
  logic [3:0]  c;
  acc_t        cur;

  always @(posedge clk) begin
    cyc = cyc + 1;
    for (int i = 1; i < CL; i++) begin
      pv[i] <= pv[i-1];
      pd[i] <= pd[i-1];
    end
    pv[0] <= 1'b0;
    if (rst_n) begin
      c = {cs_n, ras_n, cas_n, we_n};
      if (!pre_seen && c != 4'b0111)
        chk(c == 4'b0010 && addr[10] && (cyc - rst_cyc) >= PWR, "R2 precharge-all after settle", 64'(c), 64'b0010);
      case (c)
        4'b0111: ;
        4'b0010: pre_seen = 1;
        4'b0001: begin
          chk(!bank_open[0] && !bank_open[1] && !bank_open[2] && !bank_open[3], "R9 banks closed at refresh", 0, 0);
          chk(cyc - last_row >= ACT_CYC, "R6 refresh row cycle", 64'(cyc - last_row), 64'(ACT_CYC));
          chk(cyc - last_wr >= WR_REC, "R6 refresh write recovery", 64'(cyc - last_wr), 64'(WR_REC));
          if (!mrs_seen) init_refs++;
          else begin
            chk((cyc - last_ref) >= RI - 16 && (cyc - last_ref) <= RI + 16, "R9 refresh interval",
                64'(cyc - last_ref), 64'(RI));
            refs_post++;
            if (req_valid) refs_busy++;
          end
          last_ref = cyc;
          last_row = cyc;
        end
        4'b0000: begin
          chk(pre_seen && init_refs == 2, "R2 refreshes before mode set", 64'(init_refs), 2);
          chk(addr == 12'(CL << 4) && ba == 2'b00, "R2 mode op code", 64'(addr), 64'(CL << 4));
          chk(cyc - last_wr >= WR_REC, "R6 mode set write recovery", 64'(cyc - last_wr), 64'(WR_REC));
          mrs_seen = 1;
          mrs_cyc  = cyc;
          last_ref = cyc;
        end
        4'b0011: begin
          chk(exp_q.size() > 0, "R11 activate without request", 0, 1);
          if (exp_q.size() > 0) begin
            cur = exp_q[0];
            chk(ba == cur.ba && addr == cur.row, "R4 activate bank/row", 64'({ba, addr}), 64'({cur.ba, cur.row}));
          end
          chk(cyc - last_row >= ACT_CYC, "R6 activate row cycle", 64'(cyc - last_row), 64'(ACT_CYC));
          chk(cyc - last_wr >= WR_REC, "R6 activate write recovery", 64'(cyc - last_wr), 64'(WR_REC));
          bank_open[ba] = 1;
          open_row[ba]  = addr;
          last_act = cyc;
          last_row = cyc;
        end
        4'b0100, 4'b0101: begin
          chk(cyc - last_act == T_RCD, "R5 activate to column gap", 64'(cyc - last_act), 64'(T_RCD));
          chk(addr[10] && addr[11] == 1'b0 && addr[9] == 1'b0, "R4 auto precharge bit", 64'(addr), 64'h400);
          chk(bank_open[ba], "R4 column to open bank", 0, 1);
          if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            chk(addr[8:0] == cur.col && ba == cur.ba && (c == 4'b0100) == cur.we, "R4 column address",
                64'({ba, addr[8:0]}), 64'({cur.ba, cur.col}));
            if (c == 4'b0100) begin
              chk(dq == cur.wd, "R7 write data on bus", dq, cur.wd);
              chk(dqm == ~cur.be, "R7 write mask", 64'(dqm), 64'(~cur.be));
            end else begin
              chk(dqm == 8'h00, "R7 read mask low", 64'(dqm), 0);
            end
          end
          if (c == 4'b0100) begin
            logic [63:0] w;
            w = mem.exists({ba, open_row[ba], addr[8:0]}) ? mem[{ba, open_row[ba], addr[8:0]}] : 64'd0;
            for (int b = 0; b < 8; b++) if (!dqm[b]) w[b*8 +: 8] = dq[b*8 +: 8];
            mem[{ba, open_row[ba], addr[8:0]}] = w;
            last_wr = cyc;
          end else begin
            pv[0] <= 1'b1;
            pd[0] <= mem.exists({ba, open_row[ba], addr[8:0]}) ? mem[{ba, open_row[ba], addr[8:0]}] : 64'd0;
            rd_cyc_q.push_back(cyc);
          end
          bank_open[ba] = 0;
        end
        default: chk(0, "R3 illegal command code", 64'(c), 64'b0111);
      endcase
    end
  end

  // read scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      chk(exp_rd.size() > 0, "R11 unexpected read data", 0, 1);
      if (exp_rd.size() > 0) begin
        logic [63:0] e;
        int          rc;
        e  = exp_rd.pop_front();
        rc = rd_cyc_q.size() > 0 ? rd_cyc_q.pop_front() : -1;
        chk(rd_data == e, "R8 read data", rd_data, e);
        chk(cyc == rc + CL, "R8 read latency", 64'(cyc - rc), 64'(CL));
      end
    end
  end

  task automatic send(input bit we, input logic [22:0] a, input logic [63:0] d, input logic [7:0] be);
    acc_t        t;
    logic [63:0] s;
    t.we = we; t.ba = a[22:21]; t.row = a[20:9]; t.col = a[8:0]; t.wd = d; t.be = be;
    exp_q.push_back(t);
    s = shadow.exists(a) ? shadow[a] : 64'd0;
    if (we) begin
      for (int b = 0; b < 8; b++) if (be[b]) s[b*8 +: 8] = d[b*8 +: 8];
      shadow[a] = s;
    end else begin
      exp_rd.push_back(s);
    end
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 0);
    report();
  end

  initial begin
    int refs0;
    for (int i = 0; i < CL; i++) begin pv[i] = 1'b0; pd[i] = '0; end
    rst_n = 1'b0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (5) @(negedge clk);
    chk(cke == 1'b0, "R1 cke low in reset", 64'(cke), 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 NOP in reset", 64'({cs_n, ras_n, cas_n, we_n}), 64'b0111);
    chk(dqm == 8'hff, "R1 mask high in reset", 64'(dqm), 64'hff);
    chk(!req_ready && !rd_valid, "R1 ready/valid low in reset", 64'({req_ready, rd_valid}), 0);
    rst_cyc = cyc;
    rst_n = 1'b1;
    @(negedge clk);
    while (!req_ready) begin
      if (!mrs_seen && req_ready) chk(0, "R2 ready before init", 1, 0);
      @(negedge clk);
    end
    chk(mrs_seen && init_refs == 2, "R2 init done before ready", 64'(init_refs), 2);

    // directed patterns
    send(1, {2'd0, 12'h001, 9'h003}, 64'h0123_4567_89ab_cdef, 8'hff);
    send(1, {2'd1, 12'hfff, 9'h1ff}, 64'hfedc_ba98_7654_3210, 8'hff);
    send(1, {2'd2, 12'h555, 9'h0aa}, 64'h5a5a_a5a5_0f0f_f0f0, 8'hff);
    send(1, {2'd3, 12'h000, 9'h000}, 64'h1111_2222_3333_4444, 8'hff);
    send(0, {2'd0, 12'h001, 9'h003}, 0, 0);
    send(0, {2'd1, 12'hfff, 9'h1ff}, 0, 0);
    send(0, {2'd2, 12'h555, 9'h0aa}, 0, 0);
    send(0, {2'd3, 12'h000, 9'h000}, 0, 0);
    // R7 partial byte write merges with old content
    send(1, {2'd0, 12'h001, 9'h003}, 64'hffff_ffff_ffff_ffff, 8'b1010_0101);
    send(0, {2'd0, 12'h001, 9'h003}, 0, 0);
    // unwritten location reads zero
    send(0, {2'd2, 12'h123, 9'h045}, 0, 0);

    // R10: long back-to-back stream spanning several refresh deadlines
    for (int i = 0; i < 120; i++) begin
      logic [22:0] a;
      a = {2'(i), 12'(i * 37), 9'(i * 5)};
      send(1, a, {32'(i), 32'ha5a5_0000 ^ 32'(i)}, 8'hff);
      send(0, a, 0, 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(refs_busy >= 1, "R10 refresh served ahead of waiting request", 64'(refs_busy), 1);

    // R9 refresh continues while idle
    refs0 = refs_post;
    repeat (2 * RI + 40) @(negedge clk);
    chk(refs_post - refs0 >= 2, "R9 idle refreshes", 64'(refs_post - refs0), 2);
    chk(exp_q.size() == 0 && exp_rd.size() == 0, "R11 all requests completed in order",
        64'(exp_q.size() + exp_rd.size()), 0);
    report();
  end
endmodule